// File: doc/BRIEF.md
# Flash Busy and Status Generator

This block sits on the device side of a parallel flash interface. It watches write strobes for the unlock-and-command sequences that start an internal program or sector erase. While such an operation runs, it pulls an open-drain ready/busy line low. Reads taken during the operation return a status byte instead of array contents. The status byte carries a polling bit, a bit that flips on every status read, and a sector bit that flips only for reads aimed at the sector being erased.

A running erase can be suspended and later resumed. While it is suspended, a program sequence may be issued. A device reset input aborts any operation and holds the line busy while it is asserted. A configurable cycle count stands in for the timing of the memory array. When an operation finishes, a one-cycle commit pulse reports the address and data, or the sector, that the array would update.

Top module: `flash_busy_status`

## Requirements
- R1: Program starts only on the fourth write of the sequence 0xAA at UNLK_A, 0x55 at UNLK_B, 0xA0 at UNLK_A, then any address and data. The busy line is active (busy_od_o=1) from the cycle after that fourth write strobe and not before.
- R2: Erase starts only on the sixth write of the sequence 0xAA at UNLK_A, 0x55 at UNLK_B, 0x80 at UNLK_A, 0xAA at UNLK_A, 0x55 at UNLK_B, then 0x30 at any address. The sector is the top SECT_W address bits of that sixth write. The busy line is active from the cycle after that write.
- R3: A write that does not match the next expected step returns the decoder to its first step. The broken sequence starts nothing.
- R4: While a program, or an erase that is not suspended, is running, command sequences start no further operation.
- R5: A program stays busy for PGM_CYC cycles. An erase stays busy for ERS_CYC counted cycles. At the end, busy releases and exactly one commit pulse appears: commit_pgm_o with the latched address and data, or commit_ers_o with the latched sector.
- R6: Read data appears on rd_data_o one cycle after the read strobe and holds until the next read. During a program, the status byte has bit 7 equal to the inverse of bit 7 of the program data, bit 6 toggling on every read starting at 0, bit 2 set to 1, and all other bits 0. During an erase, bit 7 is 0 and bit 6 toggles. Bit 2 toggles on reads from the erasing sector and reads 1 for any other sector.
- R7: Writing 0xB0 during an erase suspends it and releases busy. The erase timer stays frozen while suspended. Writing 0x30 while the decoder is at its first step resumes the erase, and busy becomes active again.
- R8: While suspended, reads from the erasing sector return bit 7=1, bit 6=1, bit 2 toggling, and all other bits 0. Reads from any other sector return arr_data_i with bit 2 forced to 1.
- R9: While suspended, a full program sequence starts a program. Busy is active and bit 6 toggles during it, and at the end the block returns to the suspended erase.
- R10: While dev_rst_i is high, busy is active and any operation and partial sequence are discarded. The cycle after it falls, the block is in read mode with busy released.
- R11: After rst_ni, the block is in read mode with busy released, no commit pulse, and rd_data_o equal to 0.
- R12: In read mode, busy is released and reads return arr_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| dev_rst_i | input | 1 | Device reset input, active high |
| we_i | input | 1 | Write strobe, one cycle per bus write |
| re_i | input | 1 | Read strobe, one cycle per bus read |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 8 | Write data |
| arr_data_i | input | 8 | Array contents for the current address |
| busy_od_o | output | 1 | Pull-down enable of the ready/busy line (1 = busy) |
| rd_data_o | output | 8 | Read data or status byte |
| commit_pgm_o | output | 1 | Program finished pulse |
| commit_ers_o | output | 1 | Erase finished pulse |
| commit_addr_o | output | ADDR_W | Latched program address |
| commit_data_o | output | 8 | Latched program data |
| commit_sect_o | output | SECT_W | Latched erase sector |

## Verification
The program sequence is first sent whole and then cut off after three writes, which shows that busy is tied to the final write and not to an earlier step. A sequence broken by wrong data, then replayed from its second step, shows that the decoder restarts rather than resuming. Reads alternate between the erasing sector and another sector, both while running and while suspended, which separates the sector-qualified toggle from the free-running one. A program issued during suspend, a resume, and a device reset in the middle of a program show whether the counters are frozen, restored or discarded in each case.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [2:0] {
    ST_READ,
    ST_PGM,
    ST_ERS,
    ST_SUSP,
    ST_SPGM
  } op_state_e;

  localparam logic [7:0] CMD_UNLK1  = 8'hAA;
  localparam logic [7:0] CMD_UNLK2  = 8'h55;
  localparam logic [7:0] CMD_PGM    = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_EGO    = 8'h30;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;

  localparam int BIT_POLL = 7;
  localparam int BIT_TGL  = 6;
  localparam int BIT_SECT = 2;
endpackage

// File: rtl/fbs_cmd_seq.sv
module fbs_cmd_seq
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] UNLK_A = ADDR_W'('h555),
  parameter logic [ADDR_W-1:0] UNLK_B = ADDR_W'('h2AA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic              open_i,
  input  logic              ers_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              pgm_req_o,
  output logic              ers_req_o,
  output logic              seq_idle_o
);
  logic [2:0] seq_q, seq_d;
  logic at_a, at_b;

  assign at_a = (addr_i == UNLK_A);
  assign at_b = (addr_i == UNLK_B);
  assign seq_idle_o = (seq_q == 3'd0);

  always_comb begin
    seq_d     = seq_q;
    pgm_req_o = 1'b0;
    ers_req_o = 1'b0;
    if (we_i && open_i) begin
      seq_d = 3'd0;  // any mismatch restarts
      case (seq_q)
        3'd0: if (at_a && data_i == CMD_UNLK1) seq_d = 3'd1;
        3'd1: if (at_b && data_i == CMD_UNLK2) seq_d = 3'd2;
        3'd2: begin
          if (at_a && data_i == CMD_PGM) seq_d = 3'd3;
          else if (at_a && data_i == CMD_ESETUP && ers_ok_i) seq_d = 3'd4;
        end
        3'd3: pgm_req_o = 1'b1;
        3'd4: if (at_a && data_i == CMD_UNLK1) seq_d = 3'd5;
        3'd5: if (at_b && data_i == CMD_UNLK2) seq_d = 3'd6;
        3'd6: if (data_i == CMD_EGO) ers_req_o = 1'b1;
        default: seq_d = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seq_q <= 3'd0;
    else if (clr_i) seq_q <= 3'd0;
    else            seq_q <= seq_d;
  end
endmodule

// File: rtl/fbs_op_ctrl.sv
module fbs_op_ctrl
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int SECT_W  = 3,
  parameter int PGM_CYC = 16,
  parameter int ERS_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              pgm_req_i,
  input  logic              ers_req_i,
  input  logic              seq_idle_i,
  output op_state_e         state_o,
  output logic              commit_pgm_o,
  output logic              commit_ers_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [7:0]        pdata_o,
  output logic [SECT_W-1:0] sect_o
);
  localparam int PW = $clog2(PGM_CYC + 1);
  localparam int EW = $clog2(ERS_CYC + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PGM_CYC - 1);
  localparam logic [EW-1:0] E_LAST = EW'(ERS_CYC - 1);

  op_state_e         state_q;
  logic [PW-1:0]     pcnt_q;
  logic [EW-1:0]     ecnt_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [7:0]        pdata_q;
  logic [SECT_W-1:0] sect_q;
  logic              cp_q, ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      pcnt_q  <= '0;
      ecnt_q  <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
      sect_q  <= '0;
      cp_q    <= 1'b0;
      ce_q    <= 1'b0;
    end else begin
      cp_q <= 1'b0;
      ce_q <= 1'b0;
      if (clr_i) begin
        state_q <= ST_READ;
      end else begin
        case (state_q)
          ST_READ: begin
            if (pgm_req_i) begin
              state_q <= ST_PGM;
              pcnt_q  <= '0;
              paddr_q <= addr_i;
              pdata_q <= data_i;
            end else if (ers_req_i) begin
              state_q <= ST_ERS;
              ecnt_q  <= '0;
              sect_q  <= addr_i[ADDR_W-1 -: SECT_W];
            end
          end
          ST_PGM, ST_SPGM: begin
            if (pcnt_q == P_LAST) begin
              state_q <= (state_q == ST_PGM) ? ST_READ : ST_SUSP;
              cp_q    <= 1'b1;
            end else begin
              pcnt_q <= pcnt_q + PW'(1);
            end
          end
          ST_ERS: begin
            // completion wins over a same-cycle suspend
            if (ecnt_q == E_LAST) begin
              state_q <= ST_READ;
              ce_q    <= 1'b1;
            end else if (we_i && data_i == CMD_SUSP) begin
              state_q <= ST_SUSP;
            end else begin
              ecnt_q <= ecnt_q + EW'(1);
            end
          end
          ST_SUSP: begin
            if (pgm_req_i) begin
              state_q <= ST_SPGM;
              pcnt_q  <= '0;
              paddr_q <= addr_i;
              pdata_q <= data_i;
            end else if (we_i && seq_idle_i && data_i == CMD_RESUME) begin
              state_q <= ST_ERS;
            end
          end
          default: state_q <= ST_READ;
        endcase
      end
    end
  end

  assign state_o      = state_q;
  assign commit_pgm_o = cp_q;
  assign commit_ers_o = ce_q;
  assign paddr_o      = paddr_q;
  assign pdata_o      = pdata_q;
  assign sect_o       = sect_q;
endmodule

// File: rtl/fbs_status_gen.sv
module fbs_status_gen
  import flash_stat_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              re_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  input  logic [7:0]        arr_data_i,
  input  op_state_e         state_i,
  input  logic [SECT_W-1:0] ers_sect_i,
  input  logic              pbit7_i,
  input  logic              start_i,
  input  logic              ers_start_i,
  output logic [7:0]        rd_data_o
);
  logic       t6_q, t2_q, hit;
  logic [7:0] val, rd_q;

  assign hit = (rd_sect_i == ers_sect_i);

  always_comb begin
    val = '0;
    case (state_i)
      ST_PGM, ST_SPGM: begin
        val[BIT_POLL] = ~pbit7_i;
        val[BIT_TGL]  = t6_q;
        val[BIT_SECT] = 1'b1;
      end
      ST_ERS: begin
        val[BIT_TGL]  = t6_q;
        val[BIT_SECT] = hit ? t2_q : 1'b1;
      end
      ST_SUSP: begin
        if (hit) begin
          val[BIT_POLL] = 1'b1;
          val[BIT_TGL]  = 1'b1;
          val[BIT_SECT] = t2_q;
        end else begin
          val = arr_data_i;
          val[BIT_SECT] = 1'b1;
        end
      end
      default: val = arr_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (clr_i) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      if (re_i) begin
        rd_q <= val;
        if (state_i inside {ST_PGM, ST_SPGM, ST_ERS}) t6_q <= ~t6_q;
        if ((state_i inside {ST_ERS, ST_SUSP}) && hit) t2_q <= ~t2_q;
      end
      if (start_i)     t6_q <= 1'b0;
      if (ers_start_i) t2_q <= 1'b0;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int SECT_W  = 3,
  parameter int PGM_CYC = 16,
  parameter int ERS_CYC = 64,
  parameter logic [ADDR_W-1:0] UNLK_A = ADDR_W'('h555),
  parameter logic [ADDR_W-1:0] UNLK_B = ADDR_W'('h2AA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [7:0]        arr_data_i,
  output logic              busy_od_o,
  output logic [7:0]        rd_data_o,
  output logic              commit_pgm_o,
  output logic              commit_ers_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [7:0]        commit_data_o,
  output logic [SECT_W-1:0] commit_sect_o
);
  op_state_e         state;
  logic              pgm_req, ers_req, seq_idle, open, ers_ok;
  logic [SECT_W-1:0] sect;

  assign open   = (state == ST_READ) || (state == ST_SUSP);
  assign ers_ok = (state == ST_READ);

  fbs_cmd_seq #(.ADDR_W(ADDR_W), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (dev_rst_i),
    .we_i       (we_i),
    .open_i     (open),
    .ers_ok_i   (ers_ok),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .pgm_req_o  (pgm_req),
    .ers_req_o  (ers_req),
    .seq_idle_o (seq_idle)
  );

  fbs_op_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (dev_rst_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .pgm_req_i    (pgm_req),
    .ers_req_i    (ers_req),
    .seq_idle_i   (seq_idle),
    .state_o      (state),
    .commit_pgm_o (commit_pgm_o),
    .commit_ers_o (commit_ers_o),
    .paddr_o      (commit_addr_o),
    .pdata_o      (commit_data_o),
    .sect_o       (sect)
  );

  fbs_status_gen #(.SECT_W(SECT_W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (dev_rst_i),
    .re_i        (re_i),
    .rd_sect_i   (addr_i[ADDR_W-1 -: SECT_W]),
    .arr_data_i  (arr_data_i),
    .state_i     (state),
    .ers_sect_i  (sect),
    .pbit7_i     (commit_data_o[7]),
    .start_i     (pgm_req | ers_req),
    .ers_start_i (ers_req),
    .rd_data_o   (rd_data_o)
  );

  assign commit_sect_o = sect;
  assign busy_od_o = dev_rst_i || (state == ST_PGM) || (state == ST_ERS) || (state == ST_SPGM);
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dev_rst_i,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_od_o,
  input logic [7:0]        rd_data_o,
  input logic              commit_pgm_o,
  input logic              commit_ers_o
);
  assert_busy_needs_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_od_o) && !dev_rst_i) |-> $past(we_i));

  assert_pgm_commit_after_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_pgm_o |-> $past(busy_od_o));

  assert_ers_commit_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_ers_o && !dev_rst_i) |-> !busy_od_o);

  assert_single_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({commit_pgm_o, commit_ers_o}));

  assert_read_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rd_data_o));

  assert_reset_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_rst_i) |-> !busy_od_o);
endmodule

bind flash_busy_status fbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dev_rst_i    (dev_rst_i),
  .we_i         (we_i),
  .re_i         (re_i),
  .addr_i       (addr_i),
  .busy_od_o    (busy_od_o),
  .rd_data_o    (rd_data_o),
  .commit_pgm_o (commit_pgm_o),
  .commit_ers_o (commit_ers_o)
);

// File: tb/sim_flash_busy_status.sv
`timescale 1ns/1ps
module sim_flash_busy_status;
  localparam int AW = 12, SW = 3, PC = 30, EC = 80;
  localparam logic [7:0] ARR = 8'h5A;

  logic clk = 0, rst_n = 0, dev_rst = 0, we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] arr = ARR;
  logic busy, cp, ce;
  logic [7:0] rdat, cdata;
  logic [AW-1:0] caddr;
  logic [SW-1:0] csect;

  always #2 clk = ~clk;

  flash_busy_status #(.ADDR_W(AW), .SECT_W(SW), .PGM_CYC(PC), .ERS_CYC(EC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_i(dev_rst), .we_i(we), .re_i(re),
    .addr_i(addr), .data_i(data), .arr_data_i(arr), .busy_od_o(busy),
    .rd_data_o(rdat), .commit_pgm_o(cp), .commit_ers_o(ce),
    .commit_addr_o(caddr), .commit_data_o(cdata), .commit_sect_o(csect));

  int total = 0, bad = 0, cyc = 0, n_cp = 0, n_ce = 0;
  string cur = "R11";
  logic [AW-1:0] last_addr = '0;
  logic [7:0] last_data = '0;
  logic [SW-1:0] last_sect = '0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 read, 1 program, 2 erase, 3 suspended, 4 program in suspend
  int m_st = 0, m_seq = 0, m_pc = 0, m_ec = 0;
  bit m_t6 = 0, m_t2 = 0, m_cp = 0, m_ce = 0;
  logic [AW-1:0] m_pa = '0;
  logic [7:0] m_pd = '0, m_rd = '0;
  logic [SW-1:0] m_sect = '0;

  function automatic logic [7:0] m_val(input logic [AW-1:0] a);
    bit hit;
    hit = (a[AW-1 -: SW] == m_sect);
    case (m_st)
      1, 4: return {~m_pd[7], m_t6, 3'b000, 1'b1, 2'b00};
      2: return {1'b0, m_t6, 3'b000, (hit ? m_t2 : 1'b1), 2'b00};
      3: return hit ? {2'b11, 3'b000, m_t2, 2'b00} : (arr | 8'h04);
      default: return arr;
    endcase
  endfunction

  task automatic m_step();
    bit preq, ereq, idle;
    int nseq;
    m_cp = 0; m_ce = 0;
    if (dev_rst) begin
      m_st = 0; m_seq = 0; m_t6 = 0; m_t2 = 0;
      return;
    end
    if (re) begin
      m_rd = m_val(addr);
      if (m_st inside {1, 2, 4}) m_t6 = ~m_t6;
      if ((m_st == 2 || m_st == 3) && addr[AW-1 -: SW] == m_sect) m_t2 = ~m_t2;
    end
    preq = 0; ereq = 0; nseq = m_seq; idle = (m_seq == 0);
    if (we && (m_st == 0 || m_st == 3)) begin
      nseq = 0;
      case (m_seq)
        0: if (addr == 12'h555 && data == 8'hAA) nseq = 1;
        1: if (addr == 12'h2AA && data == 8'h55) nseq = 2;
        2: if (addr == 12'h555 && data == 8'hA0) nseq = 3;
           else if (addr == 12'h555 && data == 8'h80 && m_st == 0) nseq = 4;
        3: preq = 1;
        4: if (addr == 12'h555 && data == 8'hAA) nseq = 5;
        5: if (addr == 12'h2AA && data == 8'h55) nseq = 6;
        6: if (data == 8'h30) ereq = 1;
        default: nseq = 0;
      endcase
    end
    case (m_st)
      0: if (preq) begin m_st = 1; m_pc = 0; m_pa = addr; m_pd = data; end
         else if (ereq) begin m_st = 2; m_ec = 0; m_sect = addr[AW-1 -: SW]; end
      1, 4: if (m_pc == PC - 1) begin m_st = (m_st == 1) ? 0 : 3; m_cp = 1; end
            else m_pc++;
      2: if (m_ec == EC - 1) begin m_st = 0; m_ce = 1; end
         else if (we && data == 8'hB0) m_st = 3;
         else m_ec++;
      3: if (preq) begin m_st = 4; m_pc = 0; m_pa = addr; m_pd = data; end
         else if (we && idle && data == 8'h30) m_st = 2;
      default: m_st = 0;
    endcase
    m_seq = nseq;
    if (preq || ereq) m_t6 = 0;
    if (ereq) m_t2 = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_seq = 0; m_t6 = 0; m_t2 = 0; m_cp = 0; m_ce = 0; m_rd = '0;
    end else m_step();
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(cur, "busy", busy, dev_rst || (m_st inside {1, 2, 4}));
      chk(cur, "rd_data", rdat, m_rd);
      chk(cur, "commit_pgm", cp, m_cp);
      chk(cur, "commit_ers", ce, m_ce);
      if (m_cp) begin
        chk("R5", "commit_addr", caddr, m_pa);
        chk("R5", "commit_data", cdata, m_pd);
      end
      if (m_ce) chk("R5", "commit_sect", csect, m_sect);
      if (cp) begin n_cp++; last_addr = caddr; last_data = cdata; end
      if (ce) begin n_ce++; last_sect = csect; end
    end
    if (cyc > 20000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1; we = 1; addr = a; data = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(posedge clk); #1; re = 1; addr = a;
    @(posedge clk); #1; re = 0;
  endtask

  task automatic pgm_seq(input logic [AW-1:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    cur = "R11";
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "rd after reset", rdat, 0);

    cur = "R12";
    rd(12'h100); @(negedge clk);
    chk("R12", "read mode data", rdat, ARR);

    cur = "R1";
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0);
    @(negedge clk); chk("R1", "busy after 3 writes", busy, 0);
    wr(12'h123, 8'h3C);
    @(negedge clk); chk("R1", "busy after 4th write", busy, 1);

    cur = "R6";
    rd(12'h123); @(negedge clk); chk("R6", "pgm status 1", rdat, 8'h84);
    rd(12'h123); @(negedge clk); chk("R6", "pgm status 2", rdat, 8'hC4);

    cur = "R4";
    pgm_seq(12'h200, 8'h11);
    repeat (PC + 10) @(posedge clk);
    @(negedge clk);
    chk("R4", "single program commit", n_cp, 1);
    cur = "R5";
    chk("R5", "busy released", busy, 0);
    chk("R5", "commit addr", last_addr, 12'h123);
    chk("R5", "commit data", last_data, 8'h3C);

    cur = "R3";
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h99);
    wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h050, 8'h77);
    @(negedge clk); chk("R3", "broken sequence idle", busy, 0);
    pgm_seq(12'h010, 8'h80);
    @(negedge clk); chk("R3", "restart accepted", busy, 1);
    repeat (PC + 5) @(posedge clk);
    @(negedge clk); chk("R3", "second commit", n_cp, 2);

    cur = "R2";
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    @(negedge clk); chk("R2", "busy after 5 writes", busy, 0);
    wr(12'hA00, 8'h30);
    @(negedge clk); chk("R2", "busy after 6th write", busy, 1);

    cur = "R6";
    rd(12'hA10); @(negedge clk); chk("R6", "erase hit 1", rdat, 8'h00);
    rd(12'hA10); @(negedge clk); chk("R6", "erase hit 2", rdat, 8'h44);
    rd(12'h010); @(negedge clk); chk("R6", "erase other sector", rdat, 8'h04);

    cur = "R7";
    wr(12'h000, 8'hB0);
    @(negedge clk); chk("R7", "suspend releases", busy, 0);
    repeat (EC + 10) @(posedge clk);
    @(negedge clk); chk("R7", "erase frozen", n_ce, 0);

    cur = "R8";
    rd(12'hA00); @(negedge clk); chk("R8", "suspended hit 1", rdat, 8'hC0);
    rd(12'hA00); @(negedge clk); chk("R8", "suspended hit 2", rdat, 8'hC4);
    rd(12'h300); @(negedge clk); chk("R8", "suspended other", rdat, ARR | 8'h04);

    cur = "R9";
    pgm_seq(12'h300, 8'h7F);
    @(negedge clk); chk("R9", "suspend program busy", busy, 1);
    rd(12'h300); @(negedge clk); chk("R9", "suspend program status", rdat, 8'h84);
    rd(12'h300); @(negedge clk); chk("R9", "suspend program toggle", rdat, 8'hC4);
    repeat (PC + 5) @(posedge clk);
    @(negedge clk);
    chk("R9", "back to suspend", busy, 0);
    chk("R9", "third commit", n_cp, 3);
    rd(12'hA00); @(negedge clk); chk("R9", "still suspended", rdat, 8'hC0);

    cur = "R7";
    wr(12'h000, 8'h30);
    @(negedge clk); chk("R7", "resume busy", busy, 1);
    repeat (EC + 5) @(posedge clk);
    @(negedge clk);
    chk("R7", "erase finished", busy, 0);
    chk("R5", "erase commit count", n_ce, 1);
    chk("R5", "erase sector", last_sect, 3'd5);

    cur = "R10";
    pgm_seq(12'h040, 8'h01);
    @(posedge clk); #1 dev_rst = 1;
    @(negedge clk); chk("R10", "busy in reset", busy, 1);
    repeat (3) @(posedge clk);
    #1 dev_rst = 0;
    @(negedge clk); chk("R10", "released after reset", busy, 0);
    repeat (PC + 5) @(posedge clk);
    @(negedge clk); chk("R10", "aborted no commit", n_cp, 3);
    rd(12'h040); @(negedge clk); chk("R10", "read mode after reset", rdat, ARR);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule